// File: doc/BRIEF.md
# Byte-Lane Write Reservation Scoreboard

This block tracks outstanding register writes at byte granularity. It is organised as a matrix: function units are the rows, and the columns are the byte lanes of every register. Each register is 64 bits wide and is treated as eight independent byte lanes. A unit that issues a narrow operation reserves only the lanes named in its byte mask. The other lanes of the same register stay free for readers and for other writers.

Issue logic presents the unit index, the destination register and a byte mask. In the same cycle it receives a write-hazard flag if another unit already holds any of those lanes. Operand fetch logic gives a source register and a byte mask, and it gets back the lanes that still have a write pending. Each unit has its own completion strobe, which releases all of that unit's reservations. The most significant bit of the register index selects the register class (integer or floating point). Both classes therefore share one column space.

Top module: `bytelane_dep_matrix`

## Requirements
- R1: After reset no lane of any register is reserved: `rd_lanes` is 0 and `rd_hazard` is 0 for every register and mask.
- R2: An issue (`iss_valid`=1) to unit `iss_unit` reserves, for register `iss_reg`, exactly the lanes whose `iss_mask` bit is 1 (bit k is bits 8k+7..8k of the register). The reservation is visible on the read-check outputs from the first clock edge that samples the issue.
- R3: Lanes of a register that no unit reserved read back as free, even when other lanes of that same register are reserved.
- R4: The index MSB selects the register class. Two registers that differ only in that bit are independent columns.
- R5: `rd_lanes` equals the OR over all units of (reserved lanes for `chk_reg`) AND `chk_mask`, and `rd_hazard` is 1 exactly when `rd_lanes` is nonzero. Both outputs are combinational from the stored state.
- R6: `wr_hazard` is 1 in the same cycle when `iss_valid`=1 and `iss_mask` overlaps a lane of `iss_reg` that a unit other than `iss_unit` holds. Lanes held by `iss_unit` itself never raise it. The issue is recorded whether or not the flag is raised.
- R7: A 1 on `done_vec[u]` clears every reservation of unit u at that clock edge, and other units are not affected.
- R8: If unit u completes and receives an issue in the same cycle, the new reservation is loaded.
- R9: A unit holds one destination at a time. A new issue to it replaces its previous register and mask.
- R10: Two units may hold disjoint lanes of one register at the same time without `wr_hazard`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Issue strobe |
| iss_unit | input | $clog2(NUM_UNITS) | Issuing unit index |
| iss_reg | input | $clog2(NUM_REGS) | Destination register; MSB is the class |
| iss_mask | input | 8 | Destination byte lanes |
| wr_hazard | output | 1 | Issue overlaps a lane held by another unit |
| done_vec | input | NUM_UNITS | Per-unit completion strobes |
| chk_reg | input | $clog2(NUM_REGS) | Source register to check |
| chk_mask | input | 8 | Source byte lanes to check |
| rd_lanes | output | 8 | Requested lanes still pending |
| rd_hazard | output | 1 | Any requested lane pending |

## Verification
`wr_hazard`, `rd_lanes` and `rd_hazard` are combinational. The bench samples `wr_hazard` 1 ns after it drives an issue, which is before the edge that records that issue. Reservations and clears take effect at the edge that samples them. The bench therefore updates its own model at that edge and only then sweeps every register against nine lane masks plus the empty mask, holding issue and completion idle during the sweep. Directed cases cover shared registers, the class bit, replacement and a completion that collides with an issue. A pseudo-random stream of operations follows them.

// File: rtl/dep_pkg.sv
package dep_pkg;
  localparam int LANES = 8;
  typedef logic [LANES-1:0] lane_mask_t;
endpackage

// File: rtl/dep_row.sv
// One scoreboard row: the single destination a unit currently holds.
module dep_row
  import dep_pkg::*;
#(
  parameter int RW      = 8,
  parameter int UW      = 3,
  parameter int UNIT_ID = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iss_valid,
  input  logic [UW-1:0] iss_unit,
  input  logic [RW-1:0] iss_reg,
  input  lane_mask_t    iss_mask,
  input  logic          done,
  output logic [RW-1:0] row_reg,
  output lane_mask_t    row_mask
);
  logic          load;
  logic          en;
  logic [RW-1:0] reg_d;
  lane_mask_t    mask_d;

  always_comb begin
    load   = iss_valid && (iss_unit == UW'(UNIT_ID));
    en     = load || done;
    reg_d  = load ? iss_reg : row_reg;
    mask_d = load ? iss_mask : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_reg  <= '0;
      row_mask <= '0;
    end else if (en) begin
      row_reg  <= reg_d;
      row_mask <= mask_d;
    end
  end
endmodule

// File: rtl/dep_match.sv
// Lane overlap between one row and a queried register/mask.
module dep_match
  import dep_pkg::*;
#(
  parameter int RW = 8
) (
  input  logic [RW-1:0] row_reg,
  input  lane_mask_t    row_mask,
  input  logic [RW-1:0] q_reg,
  input  lane_mask_t    q_mask,
  output lane_mask_t    hit
);
  always_comb begin
    hit = (row_reg == q_reg) ? (row_mask & q_mask) : '0;
  end
endmodule

// File: rtl/bytelane_dep_matrix.sv
module bytelane_dep_matrix
  import dep_pkg::*;
#(
  parameter int NUM_UNITS = 8,
  parameter int NUM_REGS  = 256,
  localparam int UW = $clog2(NUM_UNITS),
  localparam int RW = $clog2(NUM_REGS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 iss_valid,
  input  logic [UW-1:0]        iss_unit,
  input  logic [RW-1:0]        iss_reg,
  input  logic [LANES-1:0]     iss_mask,
  output logic                 wr_hazard,
  input  logic [NUM_UNITS-1:0] done_vec,
  input  logic [RW-1:0]        chk_reg,
  input  logic [LANES-1:0]     chk_mask,
  output logic [LANES-1:0]     rd_lanes,
  output logic                 rd_hazard
);
  logic [RW-1:0] row_reg [NUM_UNITS];
  lane_mask_t    row_mask[NUM_UNITS];
  lane_mask_t    rd_hit  [NUM_UNITS];
  lane_mask_t    wr_hit  [NUM_UNITS];

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    dep_row #(.RW(RW), .UW(UW), .UNIT_ID(u)) row_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .iss_valid(iss_valid),
      .iss_unit (iss_unit),
      .iss_reg  (iss_reg),
      .iss_mask (iss_mask),
      .done     (done_vec[u]),
      .row_reg  (row_reg[u]),
      .row_mask (row_mask[u])
    );
    dep_match #(.RW(RW)) rd_i (
      .row_reg (row_reg[u]),
      .row_mask(row_mask[u]),
      .q_reg   (chk_reg),
      .q_mask  (chk_mask),
      .hit     (rd_hit[u])
    );
    dep_match #(.RW(RW)) wr_i (
      .row_reg (row_reg[u]),
      .row_mask(row_mask[u]),
      .q_reg   (iss_reg),
      .q_mask  (iss_mask),
      .hit     (wr_hit[u])
    );
  end

  lane_mask_t rd_acc;
  lane_mask_t wr_acc;

  always_comb begin
    rd_acc = '0;
    wr_acc = '0;
    for (int u = 0; u < NUM_UNITS; u++) begin
      rd_acc = rd_acc | rd_hit[u];
      if (iss_unit != UW'(u)) wr_acc = wr_acc | wr_hit[u];
    end
    rd_lanes  = rd_acc;
    rd_hazard = |rd_acc;
    wr_hazard = iss_valid && (|wr_acc);
  end
endmodule

// File: rtl/dep_matrix_chk.sv
module dep_matrix_chk #(
  parameter int NUM_UNITS = 8,
  parameter int NUM_REGS  = 256,
  localparam int UW = $clog2(NUM_UNITS),
  localparam int RW = $clog2(NUM_REGS)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 iss_valid,
  input logic [UW-1:0]        iss_unit,
  input logic [RW-1:0]        iss_reg,
  input logic [7:0]           iss_mask,
  input logic                 wr_hazard,
  input logic [NUM_UNITS-1:0] done_vec,
  input logic [RW-1:0]        chk_reg,
  input logic [7:0]           chk_mask,
  input logic [7:0]           rd_lanes,
  input logic                 rd_hazard
);
  // R2
  issue_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_mask != 8'h00) |=>
      ((chk_reg == $past(iss_reg) && (chk_mask & $past(iss_mask)) != 8'h00) -> rd_hazard));

  // R7
  all_done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&done_vec && !iss_valid) |=> !rd_hazard);

  // R5
  lanes_in_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lanes & ~chk_mask) == 8'h00);

  // R5
  empty_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_mask == 8'h00) |-> !rd_hazard);

  // R6
  empty_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!iss_valid || iss_mask == 8'h00) |-> !wr_hazard);
endmodule

bind bytelane_dep_matrix dep_matrix_chk #(.NUM_UNITS(NUM_UNITS), .NUM_REGS(NUM_REGS)) chk_i (
  .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_unit(iss_unit),
  .iss_reg(iss_reg), .iss_mask(iss_mask), .wr_hazard(wr_hazard),
  .done_vec(done_vec), .chk_reg(chk_reg), .chk_mask(chk_mask),
  .rd_lanes(rd_lanes), .rd_hazard(rd_hazard)
);

// File: tb/bytelane_dep_matrix_tb_top.sv
`timescale 1ns/1ps
module bytelane_dep_matrix_tb_top;
  localparam int NU = 4;
  localparam int NR = 8;
  localparam int UW = $clog2(NU);
  localparam int RW = $clog2(NR);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          iss_valid;
  logic [UW-1:0] iss_unit;
  logic [RW-1:0] iss_reg;
  logic [7:0]    iss_mask;
  logic          wr_hazard;
  logic [NU-1:0] done_vec;
  logic [RW-1:0] chk_reg;
  logic [7:0]    chk_mask;
  logic [7:0]    rd_lanes;
  logic          rd_hazard;

  int vectors = 0;
  int fails   = 0;
  bit finished = 0;

  logic [RW-1:0] m_reg [NU];
  logic [7:0]    m_mask[NU];

  always #2 clk = ~clk;

  bytelane_dep_matrix #(.NUM_UNITS(NU), .NUM_REGS(NR)) dut_i (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_unit(iss_unit),
    .iss_reg(iss_reg), .iss_mask(iss_mask), .wr_hazard(wr_hazard),
    .done_vec(done_vec), .chk_reg(chk_reg), .chk_mask(chk_mask),
    .rd_lanes(rd_lanes), .rd_hazard(rd_hazard)
  );

  task automatic check(string tag, logic [8:0] act, logic [8:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(logic [RW-1:0] r, logic [7:0] m);
    logic [7:0] acc = 8'h00;
    for (int u = 0; u < NU; u++)
      if (m_reg[u] == r) acc |= m_mask[u] & m;
    return acc;
  endfunction

  function automatic logic exp_wr(logic [UW-1:0] un, logic [RW-1:0] r, logic [7:0] m);
    logic acc = 1'b0;
    for (int u = 0; u < NU; u++)
      if (u != int'(un) && m_reg[u] == r && (m_mask[u] & m) != 8'h00) acc = 1'b1;
    return acc;
  endfunction

  task automatic sweep(string tag);
    for (int r = 0; r < NR; r++) begin
      for (int b = 0; b < 10; b++) begin
        logic [7:0] m;
        logic [7:0] e;
        m = (b < 8) ? (8'h01 << b) : ((b == 8) ? 8'hFF : 8'h00);
        chk_reg  = RW'(r);
        chk_mask = m;
        #1;
        e = exp_rd(RW'(r), m);
        check(tag, {rd_hazard, rd_lanes}, {(e != 8'h00), e});
      end
    end
  endtask

  task automatic step(string wtag, logic v, logic [UW-1:0] un, logic [RW-1:0] r,
                      logic [7:0] m, logic [NU-1:0] dn);
    @(negedge clk);
    iss_valid = v; iss_unit = un; iss_reg = r; iss_mask = m; done_vec = dn;
    #1;
    check(wtag, {8'h00, wr_hazard}, {8'h00, v && exp_wr(un, r, m)});
    @(posedge clk);
    for (int u = 0; u < NU; u++) begin
      if (v && int'(un) == u) begin m_reg[u] = r; m_mask[u] = m; end
      else if (dn[u]) m_mask[u] = 8'h00;
    end
    #1;
    iss_valid = 1'b0; done_vec = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    rst_n = 1'b0; iss_valid = 1'b0; iss_unit = '0; iss_reg = '0; iss_mask = '0;
    done_vec = '0; chk_reg = '0; chk_mask = '0;
    for (int u = 0; u < NU; u++) begin m_reg[u] = '0; m_mask[u] = 8'h00; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1: nothing reserved after reset
    sweep("R1");
    // R2: unit 0 takes lane 0 of reg 5 (index MSB set: second class)
    step("R6", 1'b1, 2'd0, 3'd5, 8'h01, '0);
    sweep("R2");
    // R3: the other seven lanes of reg 5 remain free
    chk_reg = 3'd5; chk_mask = 8'hFE; #1;
    check("R3", {rd_hazard, rd_lanes}, 9'h000);
    // R10: unit 1 takes lane 1 of reg 5, no write conflict
    step("R10", 1'b1, 2'd1, 3'd5, 8'h02, '0);
    sweep("R10");
    // R6: unit 2 overlaps lanes 0/1 held by units 0 and 1
    step("R6", 1'b1, 2'd2, 3'd5, 8'h03, '0);
    // R4: reg 1 (same low bits as 5, other class) is independent
    step("R4", 1'b1, 2'd3, 3'd1, 8'hFF, '0);
    sweep("R4");
    // R7: unit 2 completes, others keep theirs
    step("R7", 1'b0, 2'd0, 3'd0, 8'h00, 4'b0100);
    sweep("R7");
    // R9: unit 0 re-issues onto its own lane; own hold ignored, replaces
    step("R6", 1'b1, 2'd0, 3'd5, 8'h01, '0);
    step("R9", 1'b1, 2'd0, 3'd2, 8'h0F, '0);
    sweep("R9");
    // R8: completion and issue to unit 1 in the same cycle
    step("R8", 1'b1, 2'd1, 3'd2, 8'hF0, 4'b0010);
    sweep("R8");
    // R7: everything completes
    step("R7", 1'b0, 2'd0, 3'd0, 8'h00, 4'b1111);
    sweep("R7");
    // R5: pseudo-random mix of issues and completions
    lfsr = 16'hACE1;
    for (int i = 0; i < 200; i++) begin
      logic [NU-1:0] dn;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      dn = (lfsr[15:14] == 2'b00) ? (4'b0001 << lfsr[6:5]) : 4'b0000;
      step("R6", lfsr[13], lfsr[1:0], lfsr[4:2], lfsr[12:5], dn);
      sweep("R5");
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule